// File: doc/BRIEF.md
# Universal Interrupt Controller Core

This block gathers 32 interrupt request lines, conditions each one according to its own programmable polarity and trigger mode, and records every qualifying event in a pending-status register. Software clears pending bits by writing ones to that register. A per-source enable register masks the pending bits. A per-source routing register sends each enabled pending bit either to a critical request output or to a non-critical request output.

The block also reports the number of the most urgent enabled pending source, where a lower source number is more urgent. Its non-critical output can feed one request line of a parent controller of the same kind, so controllers can be chained. Software reaches six word registers through a small register port. A read returns its data one cycle after the request.

Top module: `irqc_core`

## Requirements
- R1: Source n sits at bit 31-n of every register and of the request input vector, so source 0 is bit 31 and source 31 is bit 0.
- R2: In level mode (trigger bit 0), a pending bit sets while its input is at the active level. If software clears it while the input is still active, it sets again.
- R3: In edge mode (trigger bit 1), a pending bit sets only on the selected transition of the input. It stays set after the input returns, and once cleared it stays clear until the next such transition.
- R4: A polarity bit of 1 selects active-high level or rising edge. A polarity bit of 0 selects active-low level or falling edge.
- R5: Writing the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. A set request in the same cycle wins over the clear.
- R6: The masked-status register reads as pending AND enable, and it is read-only: writes to it change no register. A disabled source still sets its pending bit but raises no output.
- R7: An enabled pending source whose routing bit is 1 drives the critical output, and one whose routing bit is 0 drives the non-critical output. Each output is the OR of its sources and changes one cycle after the pending or enable value it depends on.
- R8: When the masked status is non-zero, the pending-source valid output is 1. The pending-source number output then gives the lowest-numbered enabled pending source (the most significant set bit), one cycle after the masked status. When the masked status is zero, the valid output is 0.
- R9: After reset the pending, enable, routing and trigger registers read 0, the polarity register reads all ones, and all outputs are 0.
- R10: Register addresses are: 0 pending, 1 enable, 2 routing, 3 polarity, 4 trigger, 5 masked status. Addresses 6 and 7 read 0. Read data and its valid flag appear in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | 32 | Raw request lines, source n at bit 31-n |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the read strobe |
| irq_ncrit_o | output | 1 | Non-critical request, chainable into a parent |
| irq_crit_o | output | 1 | Critical request |
| pend_valid_o | output | 1 | Some enabled source is pending |
| pend_src_o | output | 5 | Number of the most urgent enabled pending source |

## Verification
The checker assumes that a pending bit can only drop in the cycle after a write to the pending register. It also assumes that writes to the masked-status address reach no stored register, and that the bus strobes are never unknown once reset is released. The stimulus drives the strobes and request lines only on falling clock edges, holds each strobe for a single cycle, and never writes and reads in the same cycle. Request lines are held for several cycles so that every change passes through the synchronizer. Each source's polarity is reprogrammed only while its line sits at a known level, so the effect of the change can be predicted.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_PEND  = 3'd0,
    SEL_ENAB  = 3'd1,
    SEL_ROUTE = 3'd2,
    SEL_POL   = 3'd3,
    SEL_TRIG  = 3'd4,
    SEL_MASK  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/irqc_sync_edge.sv
module irqc_sync_edge #(
  parameter int NSRC        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_raw_i,
  input  logic [NSRC-1:0] pol_i,
  input  logic [NSRC-1:0] trig_i,
  output logic [NSRC-1:0] set_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][NSRC-1:0] stage_q;
  logic [NSRC-1:0]                  prev_q;

  // shift chain: element 0 samples the raw lines
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      prev_q  <= '0;
    end else begin
      stage_q <= {stage_q[SYNC_STAGES-2:0], irq_raw_i};
      prev_q  <= stage_q[LAST];
    end
  end

  generate
    for (genvar b = 0; b < NSRC; b++) begin : g_bit
      logic act_now, act_prev;
      // polarity 1 keeps the line as is, polarity 0 inverts it
      assign act_now  = ~(stage_q[LAST][b] ^ pol_i[b]);
      assign act_prev = ~(prev_q[b] ^ pol_i[b]);
      assign set_o[b] = trig_i[b] ? (act_now & ~act_prev) : act_now;
    end
  endgenerate
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  reg_sel_e        sel_i,
  input  logic [NSRC-1:0] wdata_i,
  input  logic [NSRC-1:0] set_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] enab_o,
  output logic [NSRC-1:0] route_o,
  output logic [NSRC-1:0] pol_o,
  output logic [NSRC-1:0] trig_o
);
  logic [NSRC-1:0] clr_mask;

  assign clr_mask = (we_i && sel_i == SEL_PEND) ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o  <= '0;
      enab_o  <= '0;
      route_o <= '0;
      pol_o   <= '1;
      trig_o  <= '0;
    end else begin
      // a new event wins over a clear in the same cycle
      pend_o <= (pend_o & ~clr_mask) | set_i;
      if (we_i) begin
        case (sel_i)
          SEL_ENAB:  enab_o  <= wdata_i;
          SEL_ROUTE: route_o <= wdata_i;
          SEL_POL:   pol_o   <= wdata_i;
          SEL_TRIG:  trig_o  <= wdata_i;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int NSRC = 32,
  parameter int SRCW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] vec_i,
  output logic            hit_o,
  output logic [SRCW-1:0] num_o
);
  always_comb begin
    num_o = '0;
    hit_o = |vec_i;
    // walk from least to most urgent; the last match is the winner
    for (int n = NSRC - 1; n >= 0; n--) begin
      if (vec_i[NSRC-1-n]) num_o = SRCW'(n);
    end
  end
endmodule

// File: rtl/irqc_core.sv
module irqc_core
  import irqc_pkg::*;
#(
  parameter int NSRC        = 32,
  parameter int SYNC_STAGES = 2,
  parameter int SRCW        = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_src_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NSRC-1:0]   bus_wdata_i,
  output logic [NSRC-1:0]   bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              irq_ncrit_o,
  output logic              irq_crit_o,
  output logic              pend_valid_o,
  output logic [SRCW-1:0]   pend_src_o
);
  reg_sel_e        sel;
  logic [NSRC-1:0] set_w, pend_w, enab_w, route_w, pol_w, trig_w, mask_w;
  logic            hit_w;
  logic [SRCW-1:0] num_w;

  assign sel    = reg_sel_e'(bus_addr_i);
  assign mask_w = pend_w & enab_w;

  irqc_sync_edge #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst(rst), .irq_raw_i(irq_src_i),
    .pol_i(pol_w), .trig_i(trig_w), .set_o(set_w)
  );

  irqc_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst(rst), .we_i(bus_we_i), .sel_i(sel),
    .wdata_i(bus_wdata_i), .set_i(set_w), .pend_o(pend_w),
    .enab_o(enab_w), .route_o(route_w), .pol_o(pol_w), .trig_o(trig_w)
  );

  irqc_prio #(.NSRC(NSRC), .SRCW(SRCW)) u_prio (
    .vec_i(mask_w), .hit_o(hit_w), .num_o(num_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_ncrit_o  <= 1'b0;
      irq_crit_o   <= 1'b0;
      pend_valid_o <= 1'b0;
      pend_src_o   <= '0;
      bus_rvalid_o <= 1'b0;
      bus_rdata_o  <= '0;
    end else begin
      irq_ncrit_o  <= |(mask_w & ~route_w);
      irq_crit_o   <= |(mask_w & route_w);
      pend_valid_o <= hit_w;
      pend_src_o   <= num_w;
      bus_rvalid_o <= bus_re_i;
      if (bus_re_i) begin
        case (sel)
          SEL_PEND:  bus_rdata_o <= pend_w;
          SEL_ENAB:  bus_rdata_o <= enab_w;
          SEL_ROUTE: bus_rdata_o <= route_w;
          SEL_POL:   bus_rdata_o <= pol_w;
          SEL_TRIG:  bus_rdata_o <= trig_w;
          SEL_MASK:  bus_rdata_o <= mask_w;
          default:   bus_rdata_o <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqc_core_chk.sv
module irqc_core_chk #(
  parameter int NSRC = 32,
  parameter int SRCW = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_we_i,
  input logic [2:0]      bus_addr_i,
  input logic [NSRC-1:0] bus_wdata_i,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] enab,
  input logic [NSRC-1:0] route,
  input logic [NSRC-1:0] set_vec,
  input logic            irq_ncrit_o,
  input logic            irq_crit_o,
  input logic            pend_valid_o,
  input logic [SRCW-1:0] pend_src_o
);
  logic [NSRC-1:0] mask_d;

  always_ff @(posedge clk) begin
    if (rst) mask_d <= '0;
    else     mask_d <= pend & enab;
  end

  // R5
  clear_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we_i && bus_addr_i == 3'd0) |=>
      ((pend & $past(bus_wdata_i) & ~$past(set_vec)) == '0));

  // R3
  sticky_pend_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_we_i && bus_addr_i == 3'd0) |=> (($past(pend) & ~pend) == '0));

  // R6
  mask_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we_i && bus_addr_i == 3'd5) |=>
      (enab == $past(enab) && route == $past(route)));

  // R7
  ncrit_out_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ncrit_o == |(mask_d & ~$past(route)));

  // R7
  crit_out_chk: assert property (@(posedge clk) disable iff (rst)
    irq_crit_o == |(mask_d & $past(route)));

  // R8
  winner_pending_chk: assert property (@(posedge clk) disable iff (rst)
    pend_valid_o |-> mask_d[NSRC-1-int'(pend_src_o)]);

  // R8
  idle_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_valid_o |-> (mask_d == '0));
endmodule

bind irqc_core irqc_core_chk #(.NSRC(NSRC), .SRCW(SRCW)) u_chk (
  .clk(clk), .rst(rst), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .pend(pend_w), .enab(enab_w), .route(route_w),
  .set_vec(set_w), .irq_ncrit_o(irq_ncrit_o), .irq_crit_o(irq_crit_o),
  .pend_valid_o(pend_valid_o), .pend_src_o(pend_src_o)
);

// File: tb/irqc_core_tb.sv
module irqc_core_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_src = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, ncrit, crit, pvalid;
  logic [4:0]  psrc;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } rd_item_t;
  rd_item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_core u_dut (
    .clk(clk), .rst(rst), .irq_src_i(irq_src), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_rvalid_o(rvalid), .irq_ncrit_o(ncrit), .irq_crit_o(crit),
    .pend_valid_o(pvalid), .pend_src_o(psrc)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bit_of(int src);
    return 32'h1 << (31 - src);
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(logic [2:0] a, logic [31:0] exp, string tag);
    rd_item_t it;
    it.exp = exp; it.tag = tag;
    @(negedge clk);
    re = 1'b1; addr = a;
    exp_q.push_back(it);
    @(negedge clk);
    re = 1'b0;
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R10 unexpected read data actual=%h expected=none", rdata);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        check(it.tag, rdata, it.exp);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(2);
    // R9 reset values
    bus_read(3'd0, 32'h0, "R9 pending reset");
    bus_read(3'd1, 32'h0, "R9 enable reset");
    bus_read(3'd2, 32'h0, "R9 routing reset");
    bus_read(3'd3, 32'hFFFF_FFFF, "R9 polarity reset");
    bus_read(3'd4, 32'h0, "R9 trigger reset");
    bus_read(3'd5, 32'h0, "R9 masked reset");
    check("R9 outputs idle", {ncrit, crit, pvalid}, 3'b000);

    // R2 level, active high; R1 bit placement
    bus_write(3'd1, bit_of(0) | bit_of(2) | bit_of(5));
    irq_src = bit_of(5);
    wait_cyc(6);
    bus_read(3'd0, 32'h0400_0000, "R1 source 5 at bit 26");
    bus_read(3'd5, 32'h0400_0000, "R6 masked equals pend and enable");
    check("R7 noncritical raised", ncrit, 1'b1);
    check("R8 winner is 5", {pvalid, psrc}, {1'b1, 5'd5});
    bus_write(3'd0, bit_of(5));
    wait_cyc(4);
    bus_read(3'd0, bit_of(5), "R2 level sets again after clear");
    irq_src = '0;
    wait_cyc(4);
    bus_write(3'd0, bit_of(5));
    wait_cyc(4);
    bus_read(3'd0, 32'h0, "R5 cleared after line dropped");
    check("R8 idle valid", pvalid, 1'b0);

    // R8 priority
    irq_src = bit_of(5) | bit_of(2);
    wait_cyc(6);
    check("R8 source 2 beats 5", {pvalid, psrc}, {1'b1, 5'd2});
    irq_src = irq_src | bit_of(0);
    wait_cyc(6);
    check("R8 source 0 beats 2", {pvalid, psrc}, {1'b1, 5'd0});
    irq_src = '0;
    wait_cyc(4);
    bus_write(3'd0, 32'hFFFF_FFFF);
    wait_cyc(3);
    bus_read(3'd0, 32'h0, "R5 all ones clears all");
    check("R8 none pending", pvalid, 1'b0);

    // R6 disabled source latches, no output; masked is read-only
    irq_src = bit_of(10);
    wait_cyc(6);
    bus_read(3'd0, bit_of(10), "R6 disabled still latches");
    bus_read(3'd5, 32'h0, "R6 masked hides disabled");
    check("R6 no output for disabled", {ncrit, crit}, 2'b00);
    bus_write(3'd5, 32'hFFFF_FFFF);
    bus_read(3'd1, 32'hA400_0000, "R6 write to masked ignored");
    bus_read(3'd5, 32'h0, "R6 masked unchanged by write");
    irq_src = '0;
    wait_cyc(4);
    bus_write(3'd0, bit_of(10));

    // R3 rising edge on source 12
    bus_write(3'd4, bit_of(12));
    irq_src = bit_of(12);
    wait_cyc(3);
    irq_src = '0;
    wait_cyc(5);
    bus_read(3'd0, bit_of(12), "R3 edge holds after line low");
    bus_write(3'd0, 32'h0);
    bus_write(3'd0, bit_of(11));
    bus_read(3'd0, bit_of(12), "R5 zero and other bits leave bit");
    bus_write(3'd0, bit_of(12));
    wait_cyc(4);
    bus_read(3'd0, 32'h0, "R3 edge stays clear");

    // R4 falling edge on source 12
    bus_write(3'd3, 32'hFFFF_FFFF & ~bit_of(12));
    irq_src = bit_of(12);
    wait_cyc(6);
    bus_read(3'd0, 32'h0, "R4 rising ignored in falling mode");
    irq_src = '0;
    wait_cyc(6);
    bus_read(3'd0, bit_of(12), "R4 falling edge latched");
    bus_write(3'd0, bit_of(12));

    // R4 active-low level on source 3
    bus_write(3'd3, 32'hFFFF_FFFF & ~bit_of(12) & ~bit_of(3));
    wait_cyc(4);
    bus_read(3'd0, bit_of(3), "R4 active low level");
    irq_src = bit_of(3);
    wait_cyc(4);
    bus_write(3'd0, bit_of(3));
    wait_cyc(4);
    bus_read(3'd0, 32'h0, "R4 high line inactive when low active");

    // R7 routing
    bus_write(3'd2, bit_of(2));
    irq_src = bit_of(3) | bit_of(2);
    wait_cyc(6);
    check("R7 critical only", {crit, ncrit}, 2'b10);
    check("R8 winner 2 on critical", psrc, 5'd2);
    irq_src = irq_src | bit_of(5);
    wait_cyc(6);
    check("R7 both outputs", {crit, ncrit}, 2'b11);
    irq_src = bit_of(3);
    wait_cyc(4);
    bus_write(3'd0, 32'hFFFF_FFFF);
    wait_cyc(3);
    check("R7 outputs drop", {crit, ncrit}, 2'b00);

    // R7 one-cycle latency after enable write
    irq_src = bit_of(3) | bit_of(10);
    wait_cyc(6);
    check("R6 disabled quiet", ncrit, 1'b0);
    bus_write(3'd1, 32'hA420_0000);
    check("R7 not yet high", ncrit, 1'b0);
    @(negedge clk);
    check("R7 high one cycle later", ncrit, 1'b1);
    check("R8 winner 10", {pvalid, psrc}, {1'b1, 5'd10});

    // R10 address decode
    bus_read(3'd7, 32'h0, "R10 unmapped reads zero");
    bus_read(3'd5, bit_of(10), "R10 masked address");
    bus_read(3'd4, bit_of(12), "R10 trigger address");
    wait_cyc(4);
    check("R10 all reads returned", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    finish_run();
  end
endmodule